// File: doc/BRIEF.md
# Ethernet Test Frame Generator

This block produces a stream of Ethernet test frames on a 64-bit streaming source with valid, ready, start-of-packet, end-of-packet and empty signals. Software programs it through a four-word register window. It writes a seed and a frame count, then sets the start bit. The block then sends the whole burst back to back and stops by itself. When the burst ends it reports done and how many frames went out.

Every frame draws its length and payload from one 32-bit LFSR, which is loaded from the seed register at start. The destination address rotates through a unicast, a multicast and a broadcast address from frame to frame. The checksum, the MAC and the PHY lie outside the block. The first data byte is carried on data[63:56].

Top module: `pktgen_stream`

## Requirements
- R1: Register map by word address. Address 0 is control and status. A write of bit0=1 starts a burst and a write of bit1=1 requests a stop. A read returns bit0 = busy and bit1 = done. Address 1 holds the frame count and address 2 the seed; both can be read and written. Address 3 is the read-only sent-frame counter. After reset every register reads 0 and src_valid is low.
- R2: A start write takes effect only while the block is idle and the count register is non-zero. It loads the LFSR with the seed, using 1 in place of a zero seed. It also clears done and the sent counter, and the block is busy from the next cycle. A start written while busy, or while the count is 0, changes nothing.
- R3: The LFSR state s steps to {s[30:0], s[31]^s[21]^s[1]^s[0]} once for every accepted beat (src_valid and src_ready both high).
- R4: The first beat of a frame carries the destination address in data[63:16] and s[15:0] in data[15:0]. Every later beat carries {s, ~s}.
- R5: The destination address depends on the frame index within the burst, taken mod 3 and counting from 0. Index 0 gives unicast 02:00:00:00:00:01, index 1 gives multicast 01:00:5E:00:00:01 and index 2 gives broadcast FF:FF:FF:FF:FF:FF.
- R6: The frame length L is s[10:0] as it stands on the first beat, clamped into 64..1518 bytes. The frame spans ceil(L/8) beats.
- R7: src_sop is high only on the first beat and src_eop only on the last beat. On the last beat src_empty equals (8 - L mod 8) mod 8, and on all other beats it is 0.
- R8: While src_valid is high and src_ready is low, src_data, src_valid, src_sop, src_eop and src_empty all hold their values.
- R9: Frames follow each other with no gap. If more frames remain, the beat after an accepted end-of-packet is a valid start-of-packet.
- R10: Once the count number of frames has been accepted, src_valid drops, busy clears and done sets.
- R11: A stop request lets the frame in flight finish. The burst then ends with done set.
- R12: The sent counter goes up by one for each accepted end-of-packet beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| src_data | output | 64 | Frame data, first byte in bits 63:56 |
| src_valid | output | 1 | Beat valid |
| src_ready | input | 1 | Sink accepts the beat |
| src_sop | output | 1 | First beat of a frame |
| src_eop | output | 1 | Last beat of a frame |
| src_empty | output | 3 | Unused bytes on the last beat |

## Verification
The clamp boundaries and the partial last beat are the hard cases, because lengths come from the LFSR and are normally beyond the stimulus's control. The length of the first frame, however, is read straight from the low bits of the seed. The bench therefore picks seeds whose low eleven bits give 5, 0x7FF and 0x155, which yield 64, 1518 and 341 bytes (empty 0, 2 and 3). A zero seed is also tried. Later frames are predicted by an independent LFSR model, while a random ready pattern exercises the hold rule. A stop is issued mid-frame, and start writes are sent while busy and with a zero count.

// File: rtl/pktgen_stream.sv
module pktgen_stream #(
  parameter int CNT_W  = 16,
  parameter int MINLEN = 64,
  parameter int MAXLEN = 1518
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [63:0] src_data,
  output logic        src_valid,
  input  logic        src_ready,
  output logic        src_sop,
  output logic        src_eop,
  output logic [2:0]  src_empty
);
  localparam int LEN_W  = $clog2(MAXLEN + 1);
  localparam int BEAT_W = $clog2(MAXLEN / 8 + 2);

  logic              busy, done, stop_req;
  logic [31:0]       lfsr, seed_r;
  logic [CNT_W-1:0]  count_r, sent_r;
  logic [1:0]        ftype;
  logic [BEAT_W-1:0] beat, last_beat;
  logic [2:0]        last_empty;

  logic [LEN_W-1:0]  raw_len, len_now;
  logic [LEN_W-1:0]  len_m1;
  logic [BEAT_W-1:0] cur_last;
  logic [2:0]        cur_empty;
  logic [47:0]       dest;
  logic              acc, first, start_ok, stop_wr, finish;

  assign raw_len  = LEN_W'(lfsr[10:0]);
  assign len_now  = (raw_len < LEN_W'(MINLEN)) ? LEN_W'(MINLEN) :
                    (raw_len > LEN_W'(MAXLEN)) ? LEN_W'(MAXLEN) : raw_len;
  assign len_m1   = len_now - LEN_W'(1);
  assign first    = (beat == '0);
  assign cur_last = first ? BEAT_W'(len_m1 >> 3) : last_beat;
  assign cur_empty = first ? 3'(4'd8 - {1'b0, len_now[2:0]}) : last_empty;

  always_comb begin
    case (ftype)
      2'd0:    dest = 48'h02_00_00_00_00_01;
      2'd1:    dest = 48'h01_00_5E_00_00_01;
      default: dest = 48'hFF_FF_FF_FF_FF_FF;
    endcase
  end

  assign src_valid = busy;
  assign src_sop   = busy & first;
  assign src_eop   = busy & (beat == cur_last);
  assign src_empty = src_eop ? cur_empty : 3'd0;
  assign src_data  = first ? {dest, lfsr[15:0]} : {lfsr, ~lfsr};

  assign acc      = src_valid & src_ready;
  assign start_ok = reg_wr & (reg_addr == 2'd0) & reg_wdata[0] & ~busy & (count_r != '0);
  assign stop_wr  = reg_wr & (reg_addr == 2'd0) & reg_wdata[1] & busy;
  assign finish   = (sent_r + CNT_W'(1) == count_r) | stop_req | stop_wr;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {30'd0, done, busy};
      2'd1:    reg_rdata = 32'(count_r);
      2'd2:    reg_rdata = seed_r;
      default: reg_rdata = 32'(sent_r);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      stop_req   <= 1'b0;
      lfsr       <= 32'd1;
      seed_r     <= '0;
      count_r    <= '0;
      sent_r     <= '0;
      ftype      <= '0;
      beat       <= '0;
      last_beat  <= '0;
      last_empty <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd1) count_r <= reg_wdata[CNT_W-1:0];
      if (reg_wr && reg_addr == 2'd2) seed_r  <= reg_wdata;
      if (start_ok) begin
        busy     <= 1'b1;
        done     <= 1'b0;
        stop_req <= 1'b0;
        sent_r   <= '0;
        ftype    <= '0;
        beat     <= '0;
        lfsr     <= (seed_r == '0) ? 32'd1 : seed_r;
      end else begin
        if (stop_wr) stop_req <= 1'b1;
        if (acc) begin
          lfsr <= {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          if (first) begin
            last_beat  <= cur_last;
            last_empty <= cur_empty;
          end
          if (src_eop) begin
            beat   <= '0;
            sent_r <= sent_r + CNT_W'(1);
            ftype  <= (ftype == 2'd2) ? 2'd0 : ftype + 2'd1;
            if (finish) begin
              busy     <= 1'b0;
              done     <= 1'b1;
              stop_req <= 1'b0;
            end
          end else begin
            beat <= beat + BEAT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/pktgen_stream_chk.sv
module pktgen_stream_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] src_data,
  input logic        src_valid,
  input logic        src_ready,
  input logic        src_sop,
  input logic        src_eop,
  input logic [2:0]  src_empty,
  input logic        busy,
  input logic        done
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && !src_ready |=> src_valid && $stable(src_data) && $stable(src_sop)
                                && $stable(src_eop) && $stable(src_empty));

  assert_sop_eop_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |-> !(src_sop && src_eop));

  assert_next_is_sop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && src_ready && src_eop |=> !src_valid || src_sop);

  assert_dest_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && src_sop |-> (src_data[63:16] == 48'h02_00_00_00_00_01) ||
                             (src_data[63:16] == 48'h01_00_5E_00_00_01) ||
                             (src_data[63:16] == 48'hFF_FF_FF_FF_FF_FF));

  assert_busy_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !src_valid);
endmodule

bind pktgen_stream pktgen_stream_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_data(src_data), .src_valid(src_valid),
  .src_ready(src_ready), .src_sop(src_sop), .src_eop(src_eop),
  .src_empty(src_empty), .busy(busy), .done(done)
);

// File: tb/sim_pktgen_stream.sv
`timescale 1ns/1ps
module sim_pktgen_stream;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  reg_addr = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [63:0] src_data;
  logic        src_valid, src_ready = 1, src_sop, src_eop;
  logic [2:0]  src_empty;

  int checks = 0, errors = 0, frames_seen = 0;
  bit rnd_ready = 0;
  logic [68:0] exp_q[$];

  always #2 clk = ~clk;

  pktgen_stream u0 (.*);

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]}; // R3
  endfunction

  function automatic logic [47:0] dest_of(input int t);
    case (t)
      0: return 48'h02_00_00_00_00_01;
      1: return 48'h01_00_5E_00_00_01;
      default: return 48'hFF_FF_FF_FF_FF_FF;
    endcase
  endfunction

  task automatic check(input bit ok, input string what, input logic [68:0] got, input logic [68:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  // driver: model pushes every expected beat of a burst
  task automatic load_expect(input logic [31:0] seed, input int nframes);
    logic [31:0] s;
    s = (seed == 0) ? 32'd1 : seed;
    for (int f = 0; f < nframes; f++) begin
      int raw, len, nb, emp;
      raw = int'(s[10:0]);
      len = raw < 64 ? 64 : (raw > 1518 ? 1518 : raw);
      nb  = (len + 7) / 8;
      emp = (8 - len % 8) % 8;
      for (int b = 0; b < nb; b++) begin
        logic [63:0] d;
        d = (b == 0) ? {dest_of(f % 3), s[15:0]} : {s, ~s};
        exp_q.push_back({d, b == 0, b == nb - 1, (b == nb - 1) ? 3'(emp) : 3'd0});
        s = lfsr_step(s);
      end
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] st;
    for (int i = 0; i < 50000; i++) begin
      rd(2'd0, st);
      if (st[1]) return;
    end
    check(0, "R10 done never set", 0, 2);
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rd(a, v);
    check(v == e, tag, 69'(v), 69'(e));
  endtask

  always @(posedge clk) begin
    #1 src_ready <= rnd_ready ? ($urandom % 4 != 0) : 1'b1;
  end

  logic        was_stall = 0;
  logic [68:0] held;
  always @(negedge clk) begin
    logic [68:0] got;
    got = {src_data, src_sop, src_eop, src_empty};
    if (rst_n) begin
      if (was_stall)
        check(src_valid && got == held, "R8 hold while stalled", got, held);
      was_stall = src_valid && !src_ready;
      held = got;
      if (src_valid && src_ready) begin
        if (exp_q.size() == 0) check(0, "R2 R9 unexpected beat", got, 0);
        else begin
          logic [68:0] e;
          e = exp_q.pop_front();
          check(got == e, "R4 R5 R6 R7 R9 beat content", got, e);
        end
        if (src_eop) frames_seen++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    for (int a = 0; a < 4; a++) expect_reg(2'(a), 0, "R1 reset register");
    check(!src_valid, "R1 valid low after reset", 69'(src_valid), 0);

    // 64-byte first frame, ready always high
    wr(2'd2, 32'h0000_0005); wr(2'd1, 4);
    load_expect(32'h5, 4);
    wr(2'd0, 1);
    expect_reg(2'd0, 1, "R2 busy after start");
    wait_done();
    expect_reg(2'd3, 4, "R12 sent count");
    expect_reg(2'd0, 2, "R10 done status");
    check(exp_q.size() == 0, "R10 all beats seen", 69'(exp_q.size()), 0);

    // 1518-byte first frame, random ready
    rnd_ready = 1;
    wr(2'd2, 32'h1234_07FF); wr(2'd1, 3);
    load_expect(32'h1234_07FF, 3);
    wr(2'd0, 1);
    wait_done();
    expect_reg(2'd3, 3, "R12 sent count max length");
    check(exp_q.size() == 0, "R6 max length beats", 69'(exp_q.size()), 0);

    // 341-byte first frame, partial last beat
    wr(2'd2, 32'hA5A5_0155); wr(2'd1, 3);
    load_expect(32'hA5A5_0155, 3);
    wr(2'd0, 1);
    wait_done();
    check(exp_q.size() == 0, "R7 partial beat burst", 69'(exp_q.size()), 0);

    // zero seed acts as 1
    wr(2'd2, 0); wr(2'd1, 2);
    load_expect(0, 2);
    wr(2'd0, 1);
    wait_done();
    check(exp_q.size() == 0, "R2 zero seed burst", 69'(exp_q.size()), 0);
    expect_reg(2'd3, 2, "R12 sent after zero seed");

    // zero count: start ignored
    rnd_ready = 0;
    wr(2'd1, 0);
    wr(2'd0, 1);
    repeat (20) @(negedge clk);
    check(!src_valid, "R2 zero count no frames", 69'(src_valid), 0);
    expect_reg(2'd0, 2, "R2 zero count status unchanged");
    expect_reg(2'd3, 2, "R2 zero count sent unchanged");

    // start while busy ignored
    rnd_ready = 1;
    wr(2'd2, 32'h0BAD_F00D); wr(2'd1, 3);
    load_expect(32'h0BAD_F00D, 3);
    wr(2'd0, 1);
    repeat (5) @(negedge clk);
    wr(2'd2, 32'h5);
    wr(2'd0, 1);
    wait_done();
    expect_reg(2'd3, 3, "R2 start while busy ignored");
    check(exp_q.size() == 0, "R2 stream unaffected", 69'(exp_q.size()), 0);

    // stop request mid-frame
    frames_seen = 0;
    wr(2'd2, 32'h0000_0155); wr(2'd1, 5);
    load_expect(32'h0000_0155, 5);
    wr(2'd0, 1);
    while (frames_seen < 1) @(negedge clk);
    wr(2'd0, 2);
    wait_done();
    expect_reg(2'd3, 2, "R11 stop finishes current frame");
    check(frames_seen == 2, "R11 frames after stop", 69'(frames_seen), 2);
    repeat (5) @(negedge clk);
    check(!src_valid, "R11 idle after stop", 69'(src_valid), 0);
    exp_q.delete();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule